// File: doc/BRIEF.md
# Operation Sequencer with Suspend and Status

This block stands in for the automation engine behind a nonvolatile array. It starts erase, program and lock operations, and runs each one for a programmable number of clock cycles in place of the real cell algorithm. In the final busy cycle it raises a one-cycle array-write strobe that carries the operation kind. An erase or a program can be suspended and resumed later. While an erase is suspended, one program may run, and that program may itself be suspended. An 8-bit status byte reports readiness, the suspend states and sticky error flags. A read strobe freezes the byte while software samples it.

The controller has four states. IDLE waits for a start request. RUN counts the operation down. SUSP_WAIT keeps counting while the suspend latency runs out. SUSPENDED holds the remaining count. The transitions are: IDLE to RUN on an accepted start. RUN to SUSP_WAIT on a suspend request during an erase or a program. SUSP_WAIT to SUSPENDED when the latency expires. SUSPENDED to RUN on a resume, or on a program start while an erase is suspended. RUN and SUSP_WAIT go back to IDLE when the count ends, or to SUSPENDED if an erase was parked under the finishing program. A rejected start leaves the state unchanged.

Top module: `op_sequencer`

## Requirements
- R1: Reset (rst_n low, asynchronous) aborts any operation, emits no further strobe, and makes the status byte 80h with busy low.
- R2: A start is taken only in IDLE, with priority erase, then program, then lock. The operation keeps busy high for op_cycles cycles (0 counts as 1). wr_stb is high for exactly the last busy cycle, with wr_kind 0 for erase, 1 for program and 2 for lock.
- R3: A start while vpp_low is high does not run. It sets status bit 3, plus bit 5 for an erase or bit 4 for a program or lock.
- R4: A start with prot_fault high and vpp_low low does not run. It sets status bit 1, plus bit 5 for an erase or bit 4 for a program or lock.
- R5: A program that finishes with verify_fail high sets status bit 4.
- R6: Status bits 5, 4, 3 and 1 stay set until an accepted clear_req. Bit 7 is ready, bit 6 is erase suspended, bit 2 is program suspended, and bit 0 reads 0.
- R7: clear_req has no effect while bit 6 or bit 2 is set.
- R8: A suspend_req in the first busy cycle of an erase or a program clears busy after susp_latency+1 busy cycles (latency 0 counts as 1). Status then reads bits 7 and 6 (erase) or bits 7 and 2 (program). If the count ends first, the operation completes normally. A suspend_req during a lock has no effect.
- R9: After a resume, the operation runs only its remaining cycles. The busy cycles before and after the suspension add up to op_cycles.
- R10: While an erase is suspended, a program start runs a full program. When the program ends, the status reads bits 7 and 6 again, and a resume finishes the erase's remaining cycles.
- R11: While rd_n is high, status follows the internal byte one cycle late. The first cycle rd_n is sampled low captures the byte, and status holds that value until rd_n is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_erase | input | 1 | Erase start request |
| start_prog | input | 1 | Program start request |
| start_lock | input | 1 | Lock start request |
| suspend_req | input | 1 | Suspend request |
| resume_req | input | 1 | Resume request |
| clear_req | input | 1 | Clear sticky error flags |
| vpp_low | input | 1 | Programming voltage too low |
| prot_fault | input | 1 | Target protected |
| verify_fail | input | 1 | Program verify failed (sampled in the strobe cycle) |
| rd_n | input | 1 | Active-low status read strobe |
| op_cycles | input | CNT_W | Operation duration in cycles |
| susp_latency | input | CNT_W | Suspend latency in cycles |
| status | output | 8 | Status byte |
| busy | output | 1 | Operation in progress |
| wr_stb | output | 1 | Array-write strobe |
| wr_kind | output | 2 | Kind of the strobed operation |

## Verification
The assertions assume that every request is synchronous to clk and stable around the rising edge. They also assume that rd_n, the request inputs and the fault flags are not compared across the reset release. The stimulus changes inputs only on falling edges and issues each request as a single-cycle pulse. It holds rd_n high except in the capture test and never changes op_cycles or susp_latency while an operation is running. Suspend requests are placed in the first busy cycle, so the expected latency and the split of the remaining count are known in advance.

// File: rtl/opseq_pkg.sv
`timescale 1ns/1ps
package opseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_RUN       = 2'd1,
        ST_SUSP_WAIT = 2'd2,
        ST_SUSPENDED = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_ERASE = 2'd0,
        OP_PROG  = 2'd1,
        OP_LOCK  = 2'd2
    } op_kind_t;

    // error events, one bit per sticky status flag
    typedef struct packed {
        logic erase_err;
        logic prog_err;
        logic volt_err;
        logic lock_err;
    } err_evt_t;

endpackage

// File: rtl/opseq_ctrl.sv
`timescale 1ns/1ps
module opseq_ctrl
    import opseq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_erase,
    input  logic             start_prog,
    input  logic             start_lock,
    input  logic             suspend_req,
    input  logic             resume_req,
    input  logic             vpp_low,
    input  logic             prot_fault,
    input  logic             verify_fail,
    input  logic [CNT_W-1:0] op_cycles,
    input  logic [CNT_W-1:0] susp_latency,
    output logic             ready,
    output logic             erase_susp,
    output logic             prog_susp,
    output logic             wr_stb,
    output op_kind_t         wr_kind,
    output err_evt_t         evt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    seq_state_t       state_q, state_d;
    op_kind_t         op_q, op_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] lat_q, lat_d;
    logic [CNT_W-1:0] ecnt_q, ecnt_d;
    logic             park_q, park_d;

    logic             cand;
    op_kind_t         cand_op;
    logic             fault_v, fault_p, launch, finishing;

    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? ONE : v;
    endfunction

    // which start request is being considered this cycle
    always_comb begin
        cand    = 1'b0;
        cand_op = OP_ERASE;
        unique case (state_q)
            ST_IDLE: begin
                cand = start_erase | start_prog | start_lock;
                if (start_erase)     cand_op = OP_ERASE;
                else if (start_prog) cand_op = OP_PROG;
                else                 cand_op = OP_LOCK;
            end
            ST_SUSPENDED: begin
                cand    = (op_q == OP_ERASE) && start_prog && !resume_req;
                cand_op = OP_PROG;
            end
            ST_RUN, ST_SUSP_WAIT: ;
        endcase
    end

    assign fault_v   = cand && vpp_low;
    assign fault_p   = cand && !vpp_low && prot_fault;
    assign launch    = cand && !vpp_low && !prot_fault;
    assign finishing = ((state_q == ST_RUN) || (state_q == ST_SUSP_WAIT)) && (cnt_q <= ONE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        op_d    = op_q;
        cnt_d   = cnt_q;
        lat_d   = lat_q;
        ecnt_d  = ecnt_q;
        park_d  = park_q;
        unique case (state_q)
            ST_IDLE: begin
                if (launch) begin
                    state_d = ST_RUN;
                    op_d    = cand_op;
                    cnt_d   = at_least_one(op_cycles);
                end
            end
            ST_RUN, ST_SUSP_WAIT: begin
                if (finishing) begin
                    if (park_q) begin
                        state_d = ST_SUSPENDED;
                        op_d    = OP_ERASE;
                        cnt_d   = ecnt_q;
                        park_d  = 1'b0;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else begin
                    cnt_d = cnt_q - ONE;
                    if (state_q == ST_RUN) begin
                        if (suspend_req && (op_q != OP_LOCK)) begin
                            state_d = ST_SUSP_WAIT;
                            lat_d   = at_least_one(susp_latency);
                        end
                    end else if (lat_q <= ONE) begin
                        state_d = ST_SUSPENDED;
                    end else begin
                        lat_d = lat_q - ONE;
                    end
                end
            end
            ST_SUSPENDED: begin
                if (resume_req) begin
                    state_d = ST_RUN;
                end else if (launch) begin
                    park_d  = 1'b1;
                    ecnt_d  = cnt_q;
                    cnt_d   = at_least_one(op_cycles);
                    op_d    = OP_PROG;
                    state_d = ST_RUN;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_ERASE;
            cnt_q   <= '0;
            lat_q   <= '0;
            ecnt_q  <= '0;
            park_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
            cnt_q   <= cnt_d;
            lat_q   <= lat_d;
            ecnt_q  <= ecnt_d;
            park_q  <= park_d;
        end
    end

    // outputs
    always_comb begin
        ready         = (state_q == ST_IDLE) || (state_q == ST_SUSPENDED);
        erase_susp    = ((state_q == ST_SUSPENDED) && (op_q == OP_ERASE)) || park_q;
        prog_susp     = (state_q == ST_SUSPENDED) && (op_q == OP_PROG);
        wr_stb        = finishing;
        wr_kind       = op_q;
        evt.erase_err = (fault_v || fault_p) && (cand_op == OP_ERASE);
        evt.prog_err  = ((fault_v || fault_p) && (cand_op != OP_ERASE))
                        || (finishing && (op_q == OP_PROG) && verify_fail);
        evt.volt_err  = fault_v;
        evt.lock_err  = fault_p;
    end

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R2

    AST_SUSP_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(prog_susp) || $rose(erase_susp)) |-> !$past(ready)); // R8

endmodule

// File: rtl/opseq_status.sv
`timescale 1ns/1ps
module opseq_status
    import opseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_req,
    input  logic       ready,
    input  logic       erase_susp,
    input  logic       prog_susp,
    input  err_evt_t   evt,
    output logic [7:0] status_live
);

    logic [3:0] err_q;
    logic [3:0] evt_bits;
    logic       susp_any;
    logic       clear_ok;

    assign evt_bits = evt;
    assign susp_any = erase_susp || prog_susp;
    assign clear_ok = clear_req && !susp_any;

    // err_q bit order: erase, program, voltage, lock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q <= (clear_ok ? 4'b0000 : err_q) | evt_bits;
        end
    end

    assign status_live = {ready, erase_susp, err_q[3], err_q[2],
                          err_q[1], prog_susp, err_q[0], 1'b0};

    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clear_req) |-> ((err_q & $past(err_q)) == $past(err_q))); // R6

    AST_CLEAR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clear_req) && $past(susp_any)) |-> ((err_q & $past(err_q)) == $past(err_q))); // R7

    AST_VOLT_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q[1]) |-> (err_q[3] || err_q[2])); // R3

    AST_LOCK_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q[0]) |-> (err_q[3] || err_q[2])); // R4

endmodule

// File: rtl/opseq_rdcap.sv
`timescale 1ns/1ps
module opseq_rdcap (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_n,
    input  logic [7:0] status_live,
    output logic [7:0] status_q
);

    logic rd_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_prev  <= 1'b1;
            status_q <= 8'h80;
        end else begin
            rd_prev <= rd_n;
            if (rd_n || rd_prev) begin
                status_q <= status_live;
            end
        end
    end

    AST_HOLD_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !$past(rd_n) && $past(rst_n)) |=> $stable(status_q)); // R11

endmodule

// File: rtl/op_sequencer.sv
`timescale 1ns/1ps
module op_sequencer
    import opseq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_erase,
    input  logic             start_prog,
    input  logic             start_lock,
    input  logic             suspend_req,
    input  logic             resume_req,
    input  logic             clear_req,
    input  logic             vpp_low,
    input  logic             prot_fault,
    input  logic             verify_fail,
    input  logic             rd_n,
    input  logic [CNT_W-1:0] op_cycles,
    input  logic [CNT_W-1:0] susp_latency,
    output logic [7:0]       status,
    output logic             busy,
    output logic             wr_stb,
    output logic [1:0]       wr_kind
);

    logic       ready, erase_susp, prog_susp;
    op_kind_t   kind;
    err_evt_t   evt;
    logic [7:0] status_live;

    opseq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_erase  (start_erase),
        .start_prog   (start_prog),
        .start_lock   (start_lock),
        .suspend_req  (suspend_req),
        .resume_req   (resume_req),
        .vpp_low      (vpp_low),
        .prot_fault   (prot_fault),
        .verify_fail  (verify_fail),
        .op_cycles    (op_cycles),
        .susp_latency (susp_latency),
        .ready        (ready),
        .erase_susp   (erase_susp),
        .prog_susp    (prog_susp),
        .wr_stb       (wr_stb),
        .wr_kind      (kind),
        .evt          (evt)
    );

    opseq_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_req   (clear_req),
        .ready       (ready),
        .erase_susp  (erase_susp),
        .prog_susp   (prog_susp),
        .evt         (evt),
        .status_live (status_live)
    );

    opseq_rdcap u_rdcap (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_n        (rd_n),
        .status_live (status_live),
        .status_q    (status)
    );

    assign busy    = !ready;
    assign wr_kind = kind;

endmodule

// File: tb/test_op_sequencer.sv
`timescale 1ns/1ps
module test_op_sequencer;

    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_erase = 0, start_prog = 0, start_lock = 0;
    logic suspend_req = 0, resume_req = 0, clear_req = 0;
    logic vpp_low = 0, prot_fault = 0, verify_fail = 0;
    logic rd_n = 1'b1;
    logic [CNT_W-1:0] op_cycles = 16'd6;
    logic [CNT_W-1:0] susp_latency = 16'd2;
    logic [7:0] status;
    logic busy, wr_stb;
    logic [1:0] wr_kind;

    op_sequencer #(.CNT_W(CNT_W)) i_op_sequencer (
        .clk(clk), .rst_n(rst_n),
        .start_erase(start_erase), .start_prog(start_prog), .start_lock(start_lock),
        .suspend_req(suspend_req), .resume_req(resume_req), .clear_req(clear_req),
        .vpp_low(vpp_low), .prot_fault(prot_fault), .verify_fail(verify_fail),
        .rd_n(rd_n), .op_cycles(op_cycles), .susp_latency(susp_latency),
        .status(status), .busy(busy), .wr_stb(wr_stb), .wr_kind(wr_kind)
    );

    always #2 clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    int cycle_no = 0;
    int strobes = 0;
    int last_kind = -1;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // phase: 0 idle, 1 running, 2 suspend pending, 3 suspended
    int phase, kind, left, wait_left, parked_left;
    bit parked, fe, fp, fv, fl, rd_seen_high;
    bit [7:0] exp_out;

    function automatic bit [7:0] model_live();
        bit rdy, es, ps;
        rdy = (phase == 0) || (phase == 3);
        es  = ((phase == 3) && (kind == 0)) || parked;
        ps  = (phase == 3) && (kind == 1);
        return {rdy, es, fe, fp, fv, ps, fl, 1'b0};
    endfunction

    function automatic int floor1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase = 0; kind = 0; left = 0; wait_left = 0; parked_left = 0;
            parked = 0; fe = 0; fp = 0; fv = 0; fl = 0;
            rd_seen_high = 1; exp_out = 8'h80;
        end else begin
            bit [7:0] lv;
            bit frozen;
            int want;
            lv = model_live();
            if (rd_n || rd_seen_high) exp_out = lv;
            rd_seen_high = rd_n;
            frozen = (phase == 3) || parked;
            if (clear_req && !frozen) begin fe = 0; fp = 0; fv = 0; fl = 0; end
            want = -1;
            if (phase == 0) begin
                if (start_erase) want = 0;
                else if (start_prog) want = 1;
                else if (start_lock) want = 2;
            end else if (phase == 3 && !resume_req && kind == 0 && start_prog) begin
                want = 1;
            end
            if (phase == 3 && resume_req) begin
                phase = 1;
            end else if (want >= 0) begin
                if (vpp_low || prot_fault) begin
                    if (vpp_low) fv = 1; else fl = 1;
                    if (want == 0) fe = 1; else fp = 1;
                end else if (phase == 0) begin
                    phase = 1; kind = want; left = floor1(int'(op_cycles));
                end else begin
                    parked = 1; parked_left = left; kind = 1;
                    left = floor1(int'(op_cycles)); phase = 1;
                end
            end else if (phase == 1 || phase == 2) begin
                if (left <= 1) begin
                    if (kind == 1 && verify_fail) fp = 1;
                    if (parked) begin
                        phase = 3; kind = 0; left = parked_left; parked = 0;
                    end else phase = 0;
                end else begin
                    left--;
                    if (phase == 1) begin
                        if (suspend_req && kind != 2) begin
                            phase = 2; wait_left = floor1(int'(susp_latency));
                        end
                    end else if (wait_left <= 1) phase = 3;
                    else wait_left--;
                end
            end
        end
    end

    // every-clock comparison against the model
    always @(negedge clk) begin
        cycle_no++;
        if (wr_stb) begin strobes++; last_kind = int'(wr_kind); end
        if (rst_n) begin
            check("R11 status vs model", int'(status), int'(exp_out));
            check("R2 busy vs model", int'(busy), int'(!((phase == 0) || (phase == 3))));
            check("R2 strobe vs model", int'(wr_stb), int'(((phase == 1) || (phase == 2)) && left <= 1));
            if (wr_stb) check("R2 strobe kind vs model", int'(wr_kind), kind);
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic wait_idle(output int c);
        c = 0;
        while (busy && c < 1000) begin
            c++;
            @(negedge clk);
        end
    endtask

    initial begin
        int c, c1, c2, s0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        check("R1 reset status", int'(status), 8'h80);
        check("R1 reset busy", int'(busy), 0);

        // R2 plain erase
        pulse(start_erase);
        wait_idle(c);
        check("R2 erase duration", c, 6);
        check("R2 erase kind", last_kind, 0);
        tick(2);
        check("R2 idle status", int'(status), 8'h80);

        // R2 zero count treated as one
        op_cycles = 0;
        pulse(start_prog);
        wait_idle(c);
        check("R2 zero count", c, 1);
        check("R2 program kind", last_kind, 1);
        op_cycles = 6;

        // R2 priority
        start_erase = 1; start_prog = 1; start_lock = 1;
        @(negedge clk);
        start_erase = 0; start_prog = 0; start_lock = 0;
        wait_idle(c);
        check("R2 priority kind", last_kind, 0);
        tick(2);

        // R5 verify failure
        verify_fail = 1;
        pulse(start_prog);
        wait_idle(c);
        verify_fail = 0;
        tick(2);
        check("R5 verify error", int'(status), 8'h90);
        pulse(clear_req);
        tick(2);
        check("R6 clear accepted", int'(status), 8'h80);

        // R3 / R4 rejections, R6 stickiness
        vpp_low = 1;
        pulse(start_erase);
        check("R3 no run on low voltage", int'(busy), 0);
        vpp_low = 0;
        tick(2);
        check("R3 erase voltage flags", int'(status), 8'hA8);
        prot_fault = 1;
        pulse(start_prog);
        check("R4 no run on protection", int'(busy), 0);
        prot_fault = 0;
        tick(2);
        check("R4 R6 accumulated flags", int'(status), 8'hBA);
        pulse(clear_req);
        tick(2);
        vpp_low = 1;
        pulse(start_lock);
        vpp_low = 0;
        tick(2);
        check("R3 lock voltage flags", int'(status), 8'h98);
        pulse(clear_req);
        tick(2);

        // R8 / R9 erase suspend and resume
        pulse(start_erase);
        suspend_req = 1;
        @(negedge clk);
        suspend_req = 0;
        wait_idle(c1);
        c1 = c1 + 1;
        check("R8 suspend latency", c1, int'(susp_latency) + 1);
        tick(2);
        check("R8 erase suspended flags", int'(status), 8'hC0);
        pulse(resume_req);
        wait_idle(c2);
        check("R9 remaining cycles", c1 + c2, 6);
        tick(2);
        check("R9 done status", int'(status), 8'h80);

        // R10 nested program, R7 clear blocked
        pulse(start_erase);
        suspend_req = 1;
        @(negedge clk);
        suspend_req = 0;
        tick(5);
        check("R10 erase parked", int'(status), 8'hC0);
        verify_fail = 1;
        pulse(start_prog);
        wait_idle(c);
        verify_fail = 0;
        check("R10 nested program length", c, 6);
        tick(2);
        check("R10 back to erase suspend", int'(status), 8'hD0);
        pulse(clear_req);
        tick(2);
        check("R7 clear ignored while suspended", int'(status), 8'hD0);
        pulse(resume_req);
        wait_idle(c);
        check("R10 erase remainder", c, 6 - (int'(susp_latency) + 1));
        tick(2);
        check("R10 erase finished", int'(status), 8'h90);
        pulse(clear_req);
        tick(2);

        // R8 program suspend
        pulse(start_prog);
        suspend_req = 1;
        @(negedge clk);
        suspend_req = 0;
        tick(5);
        check("R8 program suspended flags", int'(status), 8'h84);
        pulse(resume_req);
        wait_idle(c);
        tick(2);
        check("R8 program resumed to idle", int'(status), 8'h80);

        // R8 suspend ignored during lock
        pulse(start_lock);
        suspend_req = 1;
        @(negedge clk);
        suspend_req = 0;
        wait_idle(c);
        check("R8 lock not suspended", c + 1, 6);
        tick(2);
        check("R8 lock status", int'(status), 8'h80);

        // R8 completion during latency
        susp_latency = 10; op_cycles = 3;
        pulse(start_erase);
        suspend_req = 1;
        @(negedge clk);
        suspend_req = 0;
        wait_idle(c);
        check("R8 finish before suspend", c + 1, 3);
        tick(2);
        check("R8 never suspended", int'(status), 8'h80);
        susp_latency = 2; op_cycles = 6;

        // R11 read capture
        rd_n = 0;
        tick(2);
        vpp_low = 1;
        pulse(start_erase);
        vpp_low = 0;
        tick(3);
        check("R11 held while read low", int'(status), 8'h80);
        rd_n = 1;
        tick(1);
        check("R11 updated after read high", int'(status), 8'hA8);
        pulse(clear_req);
        tick(2);

        // R1 reset during an operation
        pulse(start_erase);
        tick(2);
        s0 = strobes;
        rst_n = 0;
        tick(1);
        check("R1 abort status", int'(status), 8'h80);
        check("R1 abort busy", int'(busy), 0);
        rst_n = 1;
        tick(10);
        check("R1 no strobe after abort", strobes, s0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait (cycle_no > 100000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycle_no);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule